// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small processor core and decides which interrupt the core takes next. Each request line sets a sticky pending flag. A pending source can win only when its own enable bit is set, the global enable is set, and the current program counter is not in a region that the lock setting masks. Among the sources that can win, the lowest index always wins. The block offers the winner's vector address. Slot 0 of the table belongs to reset, so source `i` uses slot `i+1`.

When the core raises `core_ready` while a request is offered, the block takes the interrupt on that clock edge. On the next cycle it pulses a one-hot acknowledge for the winning source, clears that source's pending flag and clears the global enable. The global enable comes back on a return-from-interrupt pulse. Software can also set it directly inside a handler so that enabled interrupts nest. A control input moves the interrupt vectors to the boot section base. A separate configuration input moves the reset vector there.

Top module: `vpic_top`

## Requirements
- R1: After reset the global enable is 0, no pending flag is set, `irq_valid` is 0 and `irq_ack` is all zeros.
- R2: A high bit of `irq_req` sets that source's pending flag on the next clock edge. While the global enable is 0 the flag is held and `irq_valid` stays 0. Once the global enable is set, the flag is resolved.
- R3: `irq_valid` is 1 only when at least one source has its pending flag set, its `src_en` bit set, and the global enable set.
- R4: `irq_id` is the lowest index among the eligible sources.
- R5: `irq_vec` equals base + (`irq_id`+1)*VEC_STEP, with VEC_STEP = 2. The base is APP_BASE = 0x0000 when `vec_boot` = 0 and BOOT_BASE = 0x0F00 when `vec_boot` = 1.
- R6: `rst_vec` is 0x0000 when `rst_boot` = 0 and 0x0F00 when `rst_boot` = 1.
- R7: An accept happens when `core_ready` and `irq_valid` are both 1 at a clock edge. In the following cycle, `irq_ack` is one-hot at the accepted index and the global enable is 0. The accepted source's pending flag is cleared and the other pending flags stay set. `core_ready` without `irq_valid` does nothing.
- R8: A `reti` pulse or a `gie_set` pulse sets the global enable on the next edge. This allows nested interrupts.
- R9: `gie_clr` clears the global enable. Priority is: an accept beats `gie_clr`, and `gie_clr` beats `gie_set` or `reti`.
- R10: Bit 0 of `lock_mode` suppresses `irq_valid` while `pc` < 0x0F00. Bit 1 suppresses it while `pc` >= 0x0F00. Suppressed requests stay pending.
- R11: If a request arrives on the same edge that accepts that same source, its pending flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Request lines, one per source |
| src_en | input | 8 | Individual source enables |
| gie_set | input | 1 | Software pulse that sets the global enable |
| gie_clr | input | 1 | Software pulse that clears the global enable |
| reti | input | 1 | Return-from-interrupt pulse |
| vec_boot | input | 1 | Place interrupt vectors at the boot section base |
| rst_boot | input | 1 | Place the reset vector at the boot section base |
| lock_mode | input | 2 | Region lock: bit 0 masks the application region, bit 1 masks the boot region |
| pc | input | 16 | Current program counter |
| core_ready | input | 1 | Core can take an interrupt this cycle |
| irq_valid | output | 1 | An eligible request is offered |
| irq_id | output | 3 | Index of the offered source |
| irq_vec | output | 16 | Vector address of the offered source |
| rst_vec | output | 16 | Reset vector address |
| irq_ack | output | 8 | One-hot acknowledge, one cycle after an accept |
| gie | output | 1 | Current global enable |

## Verification
The hardest case to reach from the ports is an edge that does three things at once: it accepts one source, sees a new request on that same source, and leaves a lower-priority source pending. The check is that only the accepted flag is cleared, and that the fresh request survives the clear. The stimulus raises two request bits while the global enable is off, so both are held. It then sets the enable and asserts `core_ready` together with the winning request line on the same edge. After that it re-arms the enable twice, which shows that the same source returns first and the lower one after it. Region suppression is reached in the same way: the bench moves `pc` across the boot boundary while a request is held pending.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    localparam int unsigned NSRC      = 8;
    localparam int unsigned AW        = 16;
    localparam int unsigned IDW       = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef struct packed {
        logic            gie;
        logic [NSRC-1:0] ack;
    } ctl_state_t;
endpackage

// File: rtl/vpic_pend_bank.sv
module vpic_pend_bank #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = (pend_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    // Flags that were not cleared must still be set one cycle later (R2, R7)
    assert_pend_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));

    // A request seen at an edge is always pending afterwards (R11)
    assert_req_latched_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/vpic_prio_pick.sv
module vpic_prio_pick #(
    parameter int unsigned N   = 8,
    parameter int unsigned IDW = 3
) (
    input  logic [N-1:0]   elig_i,
    output logic           any_o,
    output logic [IDW-1:0] idx_o,
    output logic [N-1:0]   onehot_o
);
    logic [N:0] lower_busy;

    assign lower_busy[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign onehot_o[g]     = elig_i[g] & ~lower_busy[g];
        assign lower_busy[g+1] = lower_busy[g] | elig_i[g];
    end

    assign any_o = lower_busy[N];

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig_i[i]) idx_o = IDW'(i);
        end
    end

    // The winner is a single eligible source (R4)
    always_comb begin
        assert_pick_onehot_R4: assert ($onehot0(onehot_o) && ((onehot_o & ~elig_i) == '0));
    end
endmodule

// File: rtl/vpic_vec_calc.sv
module vpic_vec_calc #(
    parameter int unsigned AW        = 16,
    parameter int unsigned IDW       = 3,
    parameter logic [AW-1:0] APP_BASE  = 16'h0000,
    parameter logic [AW-1:0] BOOT_BASE = 16'h0F00,
    parameter int unsigned VEC_STEP  = 2
) (
    input  logic [IDW-1:0] idx_i,
    input  logic           vec_boot_i,
    input  logic           rst_boot_i,
    output logic [AW-1:0]  vec_o,
    output logic [AW-1:0]  rst_vec_o
);
    localparam logic [AW-1:0] STEP = AW'(VEC_STEP);

    logic [AW-1:0] base;
    logic [AW-1:0] slot;

    always_comb begin
        base      = vec_boot_i ? BOOT_BASE : APP_BASE;
        slot      = AW'(idx_i) + AW'(1);
        vec_o     = base + slot * STEP;
        rst_vec_o = rst_boot_i ? BOOT_BASE : APP_BASE;
    end

    // A vector never lands on its own section's reset slot (R5)
    always_comb begin
        assert_vec_past_reset_R5: assert (vec_o != base);
    end
endmodule

// File: rtl/vpic_top.sv
module vpic_top #(
    parameter int unsigned   N         = vpic_pkg::NSRC,
    parameter int unsigned   AW        = vpic_pkg::AW,
    parameter logic [15:0]   APP_BASE  = 16'h0000,
    parameter logic [15:0]   BOOT_BASE = 16'h0F00,
    parameter int unsigned   VEC_STEP  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N-1:0]                 irq_req,
    input  logic [N-1:0]                 src_en,
    input  logic                         gie_set,
    input  logic                         gie_clr,
    input  logic                         reti,
    input  logic                         vec_boot,
    input  logic                         rst_boot,
    input  logic [1:0]                   lock_mode,
    input  logic [AW-1:0]                pc,
    input  logic                         core_ready,
    output logic                         irq_valid,
    output logic [vpic_pkg::IDW-1:0]     irq_id,
    output logic [AW-1:0]                irq_vec,
    output logic [AW-1:0]                rst_vec,
    output logic [N-1:0]                 irq_ack,
    output logic                         gie
);
    import vpic_pkg::*;

    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [AW-1:0] BOOT_B = AW'(BOOT_BASE);
    localparam logic [AW-1:0] APP_B  = AW'(APP_BASE);

    typedef struct packed {
        logic         gie;
        logic [N-1:0] ack;
    } st_t;

    st_t st_d, st_q;

    logic [N-1:0] pend;
    logic [N-1:0] elig;
    logic [N-1:0] win_oh;
    logic [N-1:0] clr_mask;
    logic         any_elig;
    logic [IW-1:0] win_idx;
    logic         in_boot;
    logic         masked;
    logic         accept;

    vpic_pend_bank #(.N(N)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_req),
        .clr_i  (clr_mask),
        .pend_o (pend)
    );

    always_comb begin
        in_boot = (pc >= BOOT_B);
        masked  = (lock_mode[0] & ~in_boot) | (lock_mode[1] & in_boot);
        elig    = (st_q.gie && !masked) ? (pend & src_en) : '0;
    end

    vpic_prio_pick #(.N(N), .IDW(IW)) u_pick (
        .elig_i   (elig),
        .any_o    (any_elig),
        .idx_o    (win_idx),
        .onehot_o (win_oh)
    );

    vpic_vec_calc #(
        .AW        (AW),
        .IDW       (IW),
        .APP_BASE  (APP_B),
        .BOOT_BASE (BOOT_B),
        .VEC_STEP  (VEC_STEP)
    ) u_vec (
        .idx_i      (win_idx),
        .vec_boot_i (vec_boot),
        .rst_boot_i (rst_boot),
        .vec_o      (irq_vec),
        .rst_vec_o  (rst_vec)
    );

    always_comb begin
        accept   = core_ready & any_elig;
        clr_mask = accept ? win_oh : '0;
        st_d     = st_q;
        st_d.ack = clr_mask;
        if (accept)                st_d.gie = 1'b0;
        else if (gie_clr)          st_d.gie = 1'b0;
        else if (gie_set || reti)  st_d.gie = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_valid = any_elig;
    assign irq_id    = win_idx;
    assign irq_ack   = st_q.ack;
    assign gie       = st_q.gie;

    // Acknowledge is never more than one source (R7)
    assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack));

    // Taking an interrupt closes the global gate (R7)
    assert_gie_off_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ready && irq_valid) |=> (!gie && irq_ack != '0));

    // Offering a request requires the global gate (R3)
    assert_valid_needs_gie_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> gie);

    // Return pulse reopens the gate when nothing overrides it (R8)
    assert_reti_reopens_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !gie_clr && !(core_ready && irq_valid)) |=> gie);

    // Clear wins over set (R9)
    assert_clr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr |=> !gie);
endmodule

// File: tb/vpic_top_tb_top.sv
module vpic_top_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 6;

    // {req[7:0], en[7:0], vec_boot, exp_valid, exp_id[2:0], exp_vec[15:0]}
    localparam logic [36:0] VECS [NV] = '{
        {8'b0000_0100, 8'hFF, 1'b0, 1'b1, 3'd2, 16'h0006},
        {8'b1010_0000, 8'hFF, 1'b1, 1'b1, 3'd5, 16'h0F0C},
        {8'b0000_0011, 8'hFE, 1'b0, 1'b1, 3'd1, 16'h0004},
        {8'b1000_0000, 8'h7F, 1'b0, 1'b0, 3'd0, 16'h0000},
        {8'b1111_1111, 8'hFF, 1'b1, 1'b1, 3'd0, 16'h0F02},
        {8'b0100_0000, 8'h40, 1'b0, 1'b1, 3'd6, 16'h000E}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_req = '0;
    logic [7:0]  src_en = '0;
    logic        gie_set = 1'b0, gie_clr = 1'b0, reti = 1'b0;
    logic        vec_boot = 1'b0, rst_boot = 1'b0;
    logic [1:0]  lock_mode = 2'b00;
    logic [15:0] pc = 16'h0100;
    logic        core_ready = 1'b0;
    logic        irq_valid;
    logic [2:0]  irq_id;
    logic [15:0] irq_vec, rst_vec;
    logic [7:0]  irq_ack;
    logic        gie;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vpic_top dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .src_en(src_en),
        .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti),
        .vec_boot(vec_boot), .rst_boot(rst_boot), .lock_mode(lock_mode),
        .pc(pc), .core_ready(core_ready), .irq_valid(irq_valid),
        .irq_id(irq_id), .irq_vec(irq_vec), .rst_vec(rst_vec),
        .irq_ack(irq_ack), .gie(gie)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_req = '0; src_en = '0; gie_set = 0; gie_clr = 0; reti = 0;
        core_ready = 0; lock_mode = 0; pc = 16'h0100; vec_boot = 0; rst_boot = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic pulse_gie_set();
        @(negedge clk); gie_set = 1'b1;
        @(negedge clk); gie_set = 1'b0;
        #1;
    endtask

    task automatic drain();
        src_en = 8'hFF;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); gie_set = 1'b1; core_ready = 1'b0;
            @(negedge clk); gie_set = 1'b0; core_ready = 1'b1;
            @(negedge clk); core_ready = 1'b0;
        end
    endtask

    initial begin
        do_reset();
        // R1 reset state
        check("R1 gie", gie, 0);
        check("R1 valid", irq_valid, 0);
        check("R1 ack", irq_ack, 0);
        src_en = 8'hFF; gie_set = 1'b0;
        #1;
        check("R1 no pending", irq_valid, 0);
        pulse_gie_set();
        check("R1 pending empty after gie", irq_valid, 0);
        // R6 reset vector
        check("R6 rst_vec app", rst_vec, 16'h0000);
        rst_boot = 1'b1; #1;
        check("R6 rst_vec boot", rst_vec, 16'h0F00);
        rst_boot = 1'b0;

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic [36:0] e;
            e = VECS[v];
            do_reset();
            @(negedge clk);
            irq_req = e[36:29]; src_en = e[28:21]; vec_boot = e[20]; gie_set = 1'b1;
            @(negedge clk);
            irq_req = '0; gie_set = 1'b0;
            #1;
            check($sformatf("R3 valid vec%0d", v), irq_valid, e[19]);
            if (e[19]) begin
                check($sformatf("R4 id vec%0d", v), irq_id, e[18:16]);
                check($sformatf("R5 vector vec%0d", v), irq_vec, e[15:0]);
                core_ready = 1'b1;
                tick();
                core_ready = 1'b0;
                check($sformatf("R7 ack vec%0d", v), irq_ack, 32'(8'b1 << e[18:16]));
                check($sformatf("R7 gie off vec%0d", v), gie, 0);
                tick();
                check($sformatf("R7 ack single cycle vec%0d", v), irq_ack, 0);
            end
            drain();
        end

        // R2: hold while gie clear, then resolve
        do_reset();
        src_en = 8'hFF;
        @(negedge clk); irq_req = 8'b0000_1000;
        @(negedge clk); irq_req = '0;
        tick(); tick();
        check("R2 held while gie off", irq_valid, 0);
        pulse_gie_set();
        check("R2 resolved after gie", irq_valid, 1);
        check("R2 id", irq_id, 3);
        // R3: individual enable off
        src_en = 8'hF7; #1;
        check("R3 masked by src_en", irq_valid, 0);
        src_en = 8'hFF; #1;
        check("R3 re-enabled", irq_valid, 1);

        // R10: region lock
        lock_mode = 2'b01; pc = 16'h0100; #1;
        check("R10 app region suppressed", irq_valid, 0);
        pc = 16'h0F80; #1;
        check("R10 boot region open", irq_valid, 1);
        lock_mode = 2'b10; #1;
        check("R10 boot region suppressed", irq_valid, 0);
        pc = 16'h0EFF; #1;
        check("R10 app region open", irq_valid, 1);
        lock_mode = 2'b10; pc = 16'h0F00;
        tick(); tick();
        lock_mode = 2'b00; #1;
        check("R10 suppressed request kept", irq_valid, 1);

        // R11 and R7: accept with same-source re-request, lower source stays
        do_reset();
        src_en = 8'hFF;
        @(negedge clk); irq_req = 8'b0001_0010;
        @(negedge clk); irq_req = '0; gie_set = 1'b1;
        @(negedge clk); gie_set = 1'b0; irq_req = 8'b0000_0010; core_ready = 1'b1;
        @(negedge clk); irq_req = '0; core_ready = 1'b0;
        #1;
        check("R7 ack source 1", irq_ack, 8'b0000_0010);
        pulse_gie_set();
        check("R11 re-request kept", irq_id, 1);
        check("R11 valid", irq_valid, 1);
        core_ready = 1'b1; tick(); core_ready = 1'b0;
        pulse_gie_set();
        check("R7 other pending kept", irq_id, 4);
        check("R7 other valid", irq_valid, 1);

        // R7: ready without valid does nothing
        do_reset();
        src_en = 8'hFF;
        pulse_gie_set();
        core_ready = 1'b1; tick(); core_ready = 1'b0;
        check("R7 idle ready no ack", irq_ack, 0);
        check("R7 idle ready gie kept", gie, 1);

        // R9: clear beats set
        @(negedge clk); gie_clr = 1'b1; gie_set = 1'b1;
        @(negedge clk); gie_clr = 1'b0; gie_set = 1'b0; #1;
        check("R9 clr beats set", gie, 0);
        // R8: reti sets
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0; #1;
        check("R8 reti sets gie", gie, 1);
        // R9: accept beats set (nesting attempt on same edge)
        @(negedge clk); irq_req = 8'h01;
        @(negedge clk); irq_req = '0; core_ready = 1'b1; gie_set = 1'b1;
        @(negedge clk); core_ready = 1'b0; gie_set = 1'b0; #1;
        check("R9 accept beats set", gie, 0);
        // R8: nesting via software set
        @(negedge clk); irq_req = 8'h04;
        @(negedge clk); irq_req = '0; #1;
        check("R8 nested blocked before set", irq_valid, 0);
        pulse_gie_set();
        check("R8 nested after set", irq_valid, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule